// File: doc/BRIEF.md
# Direct-Mapped Branch Target Cache

This block lives in an instruction fetch stage and guesses, ahead of execution, that a simple branch will be taken again. It keeps a direct-mapped table in which each slot holds the full byte address of a branch, the address that branch jumped to, and a valid bit. When the fetch unit walks forward through straight-line code and reaches an address that a valid slot records, the block asks fetch to jump to the stored target in the same cycle. It also marks that fetched instruction as a predicted-taken branch, so later stages skip their own static guess.

The execute stage reports every resolved simple branch through the update port. A taken outcome fills the slot and sets its valid bit. A not-taken outcome also rewrites the slot but clears the valid bit. To keep the table read off the critical path, the block reads the slot for the address two instructions ahead (the current address plus 8) and registers it. That value is used two fetches later. As a result, the first two instructions fetched after any jump are never predicted. A build parameter removes the whole table, and the outputs then stay at zero.

Top module: `branch_target_cache`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pred_redirect` and `dec_pred_taken` are 0. Every slot written before a reset is invalid after it.
- R2: An update with `upd_taken`=1 writes the slot indexed by `upd_pc[11:2]`. If a later sequential fetch of exactly `upd_pc` has its slot read after that update, `pred_redirect` rises in that fetch cycle and `pred_target` equals `upd_target`.
- R3: An update with `upd_taken`=0 rewrites the slot and clears its valid bit. A fetch of that branch address then raises no redirect.
- R4: A fetch address that shares bits 11:2 with a stored branch but differs in any other bit (upper bits or bits 1:0) raises no redirect.
- R5: A fetch cycle with `fetch_seq`=0 never raises `pred_redirect`.
- R6: After a fetch with `fetch_seq`=0, that fetch and the next sequential fetch are never predicted. The second sequential fetch after it (the third in the run) can be.
- R7: The slot for a fetch address is read when the fetch two instructions earlier is presented. An update that lands on that same clock edge or later does not affect this prediction.
- R8: A cycle with `fetch_en`=0 raises no redirect and moves no lookahead state. A run of sequential fetches separated by stall cycles predicts exactly as it would without them.
- R9: `dec_pred_taken` is a registered copy of `pred_redirect` taken on each clock edge where `fetch_en`=1. It holds its value while `fetch_en`=0.
- R10: With the `ENABLE` parameter at 0, `pred_redirect`, `pred_target` and `dec_pred_taken` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | A fetch is presented this cycle |
| fetch_nia | input | ADDR_W | Byte address being fetched |
| fetch_seq | input | 1 | This address is the previous fetch plus 4 |
| upd_valid | input | 1 | A resolved simple branch is reported |
| upd_pc | input | ADDR_W | Byte address of the resolved branch |
| upd_target | input | ADDR_W | Branch target address |
| upd_taken | input | 1 | 1 if the branch was taken |
| pred_redirect | output | 1 | Jump fetch to `pred_target` now |
| pred_target | output | ADDR_W | Predicted target, meaningful with `pred_redirect` |
| dec_pred_taken | output | 1 | Predicted-taken mark for the instruction leaving fetch |

## Verification
The hardest situation to reach from the ports is an update that collides with the lookahead read of the same slot. The old contents must still decide the prediction two fetches later, while the very next run sees the new contents. Directed sequences place a taken update on the exact edge where the slot is read, and combine stalls and aliasing branch addresses within the same lookahead window. A long random phase then runs short forward sequences that jump on predictions, with frequent updates and stalls in a small address range where aliases are common. Every cycle is compared against a bench model of the two-stage read.

// File: rtl/btc_pkg.sv
package btc_pkg;

    // Default geometry: 1024 slots, 32-bit byte addresses.
    localparam int unsigned BTC_DEF_ADDR_W = 32;
    localparam int unsigned BTC_DEF_IDX_W  = 10;

    // Instructions are 4 bytes; index starts above the byte offset.
    localparam int unsigned BTC_OFS_W      = 2;

    // The read runs this many instructions ahead of its use.
    localparam int unsigned BTC_AHEAD_INSN = 2;
    localparam int unsigned BTC_AHEAD_BYTES = BTC_AHEAD_INSN << BTC_OFS_W;

    // Outcome carried by an update.
    typedef enum logic {
        BTC_OUT_NOT_TAKEN = 1'b0,
        BTC_OUT_TAKEN     = 1'b1
    } btc_outcome_e;

    // Status of one lookahead stage.
    typedef struct packed {
        logic live;   // read belongs to the current sequential run
        logic hit_ok; // slot valid bit at read time
    } btc_stage_flags_t;

endpackage

// File: rtl/btc_table.sv
module btc_table #(
    parameter int unsigned ADDR_W = btc_pkg::BTC_DEF_ADDR_W,
    parameter int unsigned IDX_W  = btc_pkg::BTC_DEF_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_pc,
    input  logic [ADDR_W-1:0] wr_target,
    input  btc_pkg::btc_outcome_e wr_outcome,
    output logic              rd_vbit,
    output logic [ADDR_W-IDX_W-1:0] rd_tag,
    output logic [ADDR_W-1:0] rd_target
);
    import btc_pkg::*;

    localparam int unsigned SLOTS  = 1 << IDX_W;
    localparam int unsigned TAG_W  = ADDR_W - IDX_W;
    localparam int unsigned IDX_LO = BTC_OFS_W;
    localparam int unsigned IDX_HI = BTC_OFS_W + IDX_W - 1;

    logic [TAG_W-1:0]  tag_mem [SLOTS];
    logic [ADDR_W-1:0] tgt_mem [SLOTS];
    logic [SLOTS-1:0]  vbits;

    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;

    // Tag keeps every address bit outside the index field.
    assign wr_idx = wr_pc[IDX_HI:IDX_LO];
    assign wr_tag = {wr_pc[ADDR_W-1:IDX_HI+1], wr_pc[IDX_LO-1:0]};

    // Payload storage: no reset, RAM friendly.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
            tgt_mem[wr_idx] <= wr_target;
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_tag    <= tag_mem[rd_idx];
            rd_target <= tgt_mem[rd_idx];
        end
    end

    // Valid bits in flops so a reset clears them in one cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            vbits <= '0;
        end else if (wr_en) begin
            vbits[wr_idx] <= (wr_outcome == BTC_OUT_TAKEN);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vbit <= 1'b0;
        end else if (rd_en) begin
            rd_vbit <= vbits[rd_idx];
        end
    end

endmodule

// File: rtl/btc_lookup.sv
module btc_lookup #(
    parameter int unsigned ADDR_W = btc_pkg::BTC_DEF_ADDR_W,
    parameter int unsigned IDX_W  = btc_pkg::BTC_DEF_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_en,
    input  logic [ADDR_W-1:0] fetch_nia,
    input  logic              fetch_seq,
    output logic              rd_en,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_vbit,
    input  logic [ADDR_W-IDX_W-1:0] rd_tag,
    input  logic [ADDR_W-1:0] rd_target,
    output logic              pred_redirect,
    output logic [ADDR_W-1:0] pred_target,
    output logic              dec_pred_taken
);
    import btc_pkg::*;

    localparam int unsigned TAG_W  = ADDR_W - IDX_W;
    localparam int unsigned IDX_LO = BTC_OFS_W;
    localparam int unsigned IDX_HI = BTC_OFS_W + IDX_W - 1;

    logic [ADDR_W-1:0] ahead_addr;

    // Stage 1: read issued last fetch; data sits in the table output regs.
    logic              s1_live;
    logic [ADDR_W-1:0] s1_addr;

    // Stage 2: read data aligned with the fetch that uses it.
    btc_stage_flags_t  s2_flags;
    logic [ADDR_W-1:0] s2_addr;
    logic [TAG_W-1:0]  s2_tag;
    logic [ADDR_W-1:0] s2_target;

    logic [TAG_W-1:0]  fetch_tag;
    logic              hit;

    assign ahead_addr = fetch_nia + ADDR_W'(BTC_AHEAD_BYTES);
    assign rd_en      = fetch_en;
    assign rd_idx     = ahead_addr[IDX_HI:IDX_LO];

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_live  <= 1'b0;
            s2_flags <= '0;
        end else if (fetch_en) begin
            // A non-sequential fetch kills the read issued before it.
            s2_flags.live   <= s1_live & fetch_seq;
            s2_flags.hit_ok <= rd_vbit;
            s1_live         <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fetch_en) begin
            s1_addr   <= ahead_addr;
            s2_addr   <= s1_addr;
            s2_tag    <= rd_tag;
            s2_target <= rd_target;
        end
    end

    assign fetch_tag = {fetch_nia[ADDR_W-1:IDX_HI+1], fetch_nia[IDX_LO-1:0]};

    assign hit = fetch_en && fetch_seq && s2_flags.live && s2_flags.hit_ok
              && (s2_addr == fetch_nia) && (s2_tag == fetch_tag);

    assign pred_redirect = hit;
    assign pred_target   = s2_target;

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_pred_taken <= 1'b0;
        end else if (fetch_en) begin
            dec_pred_taken <= hit;
        end
    end

endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache #(
    parameter bit          ENABLE = 1'b1,
    parameter int unsigned ADDR_W = btc_pkg::BTC_DEF_ADDR_W,
    parameter int unsigned IDX_W  = btc_pkg::BTC_DEF_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_en,
    input  logic [ADDR_W-1:0] fetch_nia,
    input  logic              fetch_seq,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              upd_taken,
    output logic              pred_redirect,
    output logic [ADDR_W-1:0] pred_target,
    output logic              dec_pred_taken
);
    import btc_pkg::*;

    localparam int unsigned TAG_W = ADDR_W - IDX_W;

    generate
        if (ENABLE) begin : g_on
            logic              rd_en;
            logic [IDX_W-1:0]  rd_idx;
            logic              rd_vbit;
            logic [TAG_W-1:0]  rd_tag;
            logic [ADDR_W-1:0] rd_target;
            btc_outcome_e      outcome;

            assign outcome = upd_taken ? BTC_OUT_TAKEN : BTC_OUT_NOT_TAKEN;

            btc_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
                .clk        (clk),
                .rst        (rst),
                .rd_en      (rd_en),
                .rd_idx     (rd_idx),
                .wr_en      (upd_valid),
                .wr_pc      (upd_pc),
                .wr_target  (upd_target),
                .wr_outcome (outcome),
                .rd_vbit    (rd_vbit),
                .rd_tag     (rd_tag),
                .rd_target  (rd_target)
            );

            btc_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lookup (
                .clk            (clk),
                .rst            (rst),
                .fetch_en       (fetch_en),
                .fetch_nia      (fetch_nia),
                .fetch_seq      (fetch_seq),
                .rd_en          (rd_en),
                .rd_idx         (rd_idx),
                .rd_vbit        (rd_vbit),
                .rd_tag         (rd_tag),
                .rd_target      (rd_target),
                .pred_redirect  (pred_redirect),
                .pred_target    (pred_target),
                .dec_pred_taken (dec_pred_taken)
            );
        end else begin : g_off
            assign pred_redirect  = 1'b0;
            assign pred_target    = '0;
            assign dec_pred_taken = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/btc_checker.sv
module btc_checker (
    input logic clk,
    input logic rst,
    input logic fetch_en,
    input logic fetch_seq,
    input logic pred_redirect,
    input logic dec_pred_taken
);

    // R5: a non-sequential fetch is never redirected
    p_seq_only_r5: assert property (@(posedge clk) disable iff (rst)
        pred_redirect |-> (fetch_en && fetch_seq));

    // R6: the fetch after a non-sequential one is not predicted either
    p_second_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (fetch_en && !fetch_seq) |=> !pred_redirect);

    // R9: the decode mark follows a redirect one edge later
    p_mark_follows_r9: assert property (@(posedge clk) disable iff (rst)
        (fetch_en && pred_redirect) |=> dec_pred_taken);

    // R8: stalls leave the decode mark unchanged
    p_mark_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !fetch_en |=> $stable(dec_pred_taken));

    // R1: first cycle after reset is quiet
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!dec_pred_taken && !pred_redirect));

endmodule

bind branch_target_cache btc_checker u_btc_chk (
    .clk            (clk),
    .rst            (rst),
    .fetch_en       (fetch_en),
    .fetch_seq      (fetch_seq),
    .pred_redirect  (pred_redirect),
    .dec_pred_taken (dec_pred_taken)
);

// File: tb/branch_target_cache_bench.sv
`timescale 1ns/1ps
module branch_target_cache_bench;

    localparam int AW = 32;
    localparam int IW = 10;
    localparam int SL = 1 << IW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fetch_en = 1'b0;
    logic [AW-1:0] fetch_nia = '0;
    logic          fetch_seq = 1'b0;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic [AW-1:0] upd_target = '0;
    logic          upd_taken = 1'b0;
    logic          pred_redirect, dec_pred_taken;
    logic [AW-1:0] pred_target;
    logic          off_redirect, off_dec;
    logic [AW-1:0] off_target;

    always #4 clk = ~clk;

    branch_target_cache #(.ENABLE(1'b1), .ADDR_W(AW), .IDX_W(IW)) u_branch_target_cache (
        .clk(clk), .rst(rst), .fetch_en(fetch_en), .fetch_nia(fetch_nia),
        .fetch_seq(fetch_seq), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_target(upd_target), .upd_taken(upd_taken),
        .pred_redirect(pred_redirect), .pred_target(pred_target),
        .dec_pred_taken(dec_pred_taken)
    );

    branch_target_cache #(.ENABLE(1'b0), .ADDR_W(AW), .IDX_W(IW)) u_off (
        .clk(clk), .rst(rst), .fetch_en(fetch_en), .fetch_nia(fetch_nia),
        .fetch_seq(fetch_seq), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_target(upd_target), .upd_taken(upd_taken),
        .pred_redirect(off_redirect), .pred_target(off_target),
        .dec_pred_taken(off_dec)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Bench model of the table and the two-stage lookahead
    bit            m_v   [SL];
    logic [AW-1:0] m_pc  [SL];
    logic [AW-1:0] m_tgt [SL];
    bit            a1_live;
    logic [AW-1:0] a1_addr;
    bit            a1_v;
    logic [AW-1:0] a1_pc, a1_tgt;
    bit            a2_live;
    logic [AW-1:0] a2_addr;
    bit            a2_v;
    logic [AW-1:0] a2_pc, a2_tgt;
    bit            exp_dec;
    bit            last_exp;
    logic [AW-1:0] last_tgt;

    function automatic int slot(input logic [AW-1:0] a);
        return int'(a[IW+1:2]);
    endfunction

    function automatic bit model_hit(input bit en, input bit seq, input logic [AW-1:0] nia);
        return en && seq && a2_live && a2_v && (a2_addr == nia) && (a2_pc == nia);
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < SL; i++) m_v[i] = 1'b0;
        a1_live = 1'b0;
        a2_live = 1'b0;
        exp_dec = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; fetch_en = 1'b0; upd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        check("R1 redirect after reset", AW'(pred_redirect), 0);
        check("R1 mark after reset", AW'(dec_pred_taken), 0);
    endtask

    // One cycle: drive at negedge, check outputs, then advance the model at posedge.
    task automatic cyc(input string req, input bit en, input logic [AW-1:0] nia, input bit seq,
                       input bit uv, input logic [AW-1:0] upc, input logic [AW-1:0] utgt, input bit utk);
        bit e;
        @(negedge clk);
        check("R9 decode mark", AW'(dec_pred_taken), AW'(exp_dec));
        fetch_en = en; fetch_nia = nia; fetch_seq = seq;
        upd_valid = uv; upd_pc = upc; upd_target = utgt; upd_taken = utk;
        #1;
        e = model_hit(en, seq, nia);
        check(req, AW'(pred_redirect), AW'(e));
        if (e) check({req, " target"}, pred_target, a2_tgt);
        check("R10 disabled outputs", AW'({off_redirect, off_dec}) | off_target, 0);
        last_exp = e;
        last_tgt = a2_tgt;
        @(posedge clk);
        if (en) begin
            a2_live = a1_live && seq;
            a2_addr = a1_addr; a2_v = a1_v; a2_pc = a1_pc; a2_tgt = a1_tgt;
            a1_live = 1'b1;
            a1_addr = nia + 8;
            a1_v   = m_v[slot(a1_addr)];
            a1_pc  = m_pc[slot(a1_addr)];
            a1_tgt = m_tgt[slot(a1_addr)];
            exp_dec = e;
        end
        if (uv) begin
            m_v[slot(upc)]   = utk;
            m_pc[slot(upc)]  = upc;
            m_tgt[slot(upc)] = utgt;
        end
    endtask

    task automatic upd(input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input bit tk);
        cyc("R8 idle", 1'b0, 32'h0, 1'b0, 1'b1, pc, tgt, tk);
    endtask

    // Fetch a run starting at s (non-sequential) for n instructions.
    task automatic run(input string req, input logic [AW-1:0] s, input int n);
        for (int k = 0; k < n; k++)
            cyc(req, 1'b1, s + AW'(4 * k), (k != 0), 1'b0, 0, 0, 1'b0);
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] nia;
        bit            seq;
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();

        // R2: taken branch at 0x100 predicted on third sequential fetch
        upd(32'h100, 32'h2000, 1'b1);
        run("R2 taken hit", 32'hF8, 3);
        check("R2 redirect seen", AW'(last_exp), 1);
        cyc("R2 follow", 1'b1, 32'h2000, 1'b0, 1'b0, 0, 0, 1'b0);

        // R5/R6: too close to the jump
        run("R5 nonseq fetch", 32'h100, 1);
        run("R6 second fetch", 32'hFC, 2);
        check("R6 no redirect on second", AW'(last_exp), 0);

        // R8: stalls inside the lookahead window
        cyc("R8 run", 1'b1, 32'hF8, 1'b0, 1'b0, 0, 0, 1'b0);
        cyc("R8 run", 1'b1, 32'hFC, 1'b1, 1'b0, 0, 0, 1'b0);
        for (int k = 0; k < 3; k++) cyc("R8 stall", 1'b0, 32'h100, 1'b1, 1'b0, 0, 0, 1'b0);
        cyc("R8 after stall", 1'b1, 32'h100, 1'b1, 1'b0, 0, 0, 1'b0);
        check("R8 redirect after stall", AW'(last_exp), 1);
        cyc("R9 stall holds mark", 1'b0, 32'h2000, 1'b0, 1'b0, 0, 0, 1'b0);
        cyc("R9 stall holds mark", 1'b0, 32'h2000, 1'b0, 1'b0, 0, 0, 1'b0);

        // R4: alias with same index, different upper bits and low bits
        run("R4 alias upper", 32'h10F8, 3);
        check("R4 alias upper no redirect", AW'(last_exp), 0);
        upd(32'h1100, 32'h3000, 1'b1);
        run("R4 alias now stored", 32'h10F8, 3);
        check("R4 stored alias hit", AW'(last_exp), 1);
        run("R4 old branch evicted", 32'hF8, 3);
        check("R4 evicted no redirect", AW'(last_exp), 0);
        upd(32'h100, 32'h2000, 1'b1);
        run("R4 low bits differ", 32'hFA, 3);
        check("R4 low bits no redirect", AW'(last_exp), 0);

        // R3: not-taken clears
        upd(32'h100, 32'h2000, 1'b0);
        run("R3 not taken", 32'hF8, 3);
        check("R3 cleared no redirect", AW'(last_exp), 0);

        // R7: update on the read edge is not seen by this run
        cyc("R7 read edge", 1'b1, 32'hF8, 1'b0, 1'b1, 32'h100, 32'h4000, 1'b1);
        cyc("R7 window", 1'b1, 32'hFC, 1'b1, 1'b0, 0, 0, 1'b0);
        cyc("R7 stale slot", 1'b1, 32'h100, 1'b1, 1'b0, 0, 0, 1'b0);
        check("R7 stale no redirect", AW'(last_exp), 0);
        run("R7 next run sees it", 32'hF8, 3);
        check("R7 later hit", AW'(last_exp), 1);
        check("R7 later target", last_tgt, 32'h4000);

        // R1: reset wipes valid bits
        do_reset();
        run("R1 wiped after reset", 32'hF8, 3);
        check("R1 no redirect after reset", AW'(last_exp), 0);

        // Random phase
        nia = 32'h1000; seq = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            bit en, uv, tk;
            logic [AW-1:0] upc, utg;
            en  = ($urandom_range(99) >= 6);
            uv  = ($urandom_range(99) < 30);
            tk  = ($urandom_range(99) < 75);
            upc = 32'h1000 + AW'(4 * $urandom_range(63));
            if ($urandom_range(99) < 20) upc = upc + 32'h1000;
            utg = 32'h1000 + AW'(4 * $urandom_range(63));
            cyc("R2 random", en, nia, seq, uv, upc, utg, tk);
            if (en) begin
                if (last_exp) begin
                    nia = last_tgt; seq = 1'b0;
                end else if ($urandom_range(99) < 8) begin
                    nia = 32'h1000 + AW'(4 * $urandom_range(63));
                    if ($urandom_range(99) < 20) nia = nia + 32'h1000;
                    seq = 1'b0;
                end else begin
                    nia = nia + 4; seq = 1'b1;
                end
            end
        end
        cyc("R9 final", 1'b0, nia, 1'b0, 1'b0, 0, 0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule